// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

A synchronous 2K x 8 memory with two identical and fully independent ports, called left and right. Each port has its own chip select, write enable, output enable, 11-bit address, 8-bit write data and registered 8-bit read data. Either port may read or write any word in any cycle. The block does not arbitrate: a same-address collision resolves to a fixed winner.

The two highest words act as mailboxes between the ports. When one port writes its notify word, an interrupt flag is raised toward the other port. The receiving port takes down that flag by reading its own mailbox word with output enable asserted. The message byte is ordinary storage. Each port also reports a standby indication whenever it is not selected. A deselected port touches neither the memory nor any flag.

Top module: `dpmb_top`

## Requirements
- R1: A read happens when a port has cs=1, we=0 and oe=1. The word at its address appears on that port's rdata after the next rising clock edge. Every one of the 2048 locations is readable and writable from both ports.
- R2: A port's rdata keeps its value in every cycle in which that port does not perform a read.
- R3: When both ports write the same address in the same cycle, the left port's data is stored.
- R4: A read in the same cycle as a write to that address by the other port returns the contents from before the write.
- R5: A right-port write (cs=1, we=1) to address 0x7FE drives lp_irq_n low after that clock edge.
- R6: A left-port write (cs=1, we=1) to address 0x7FF drives rp_irq_n low after that clock edge.
- R7: With cs=1 and oe=1 at address 0x7FE, the left port returns lp_irq_n high after the edge, whatever the value of we.
- R8: With cs=1 and oe=1 at address 0x7FF, the right port returns rp_irq_n high after the edge, whatever the value of we.
- R9: If a flag is set and cleared in the same cycle, it ends up set.
- R10: The words at 0x7FE and 0x7FF store and return data like any other location.
- R11: A port's standby output equals the inverse of its cs, without delay. While cs=0 the port writes nothing, leaves rdata unchanged, and neither sets nor clears any flag.
- R12: After reset both irq_n outputs are high. Memory contents are not initialised.
- R13: A flag changes only through R5 to R9. In particular, a port writing its own mailbox with oe=0 neither sets nor clears its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lp_cs | input | 1 | Left chip select, active high |
| lp_we | input | 1 | Left write enable, active high |
| lp_oe | input | 1 | Left output enable, active high |
| lp_addr | input | 11 | Left address |
| lp_wdata | input | 8 | Left write data |
| lp_rdata | output | 8 | Left registered read data |
| lp_standby | output | 1 | Left standby indication |
| lp_irq_n | output | 1 | Left mailbox interrupt, active low |
| rp_cs | input | 1 | Right chip select, active high |
| rp_we | input | 1 | Right write enable, active high |
| rp_oe | input | 1 | Right output enable, active high |
| rp_addr | input | 11 | Right address |
| rp_wdata | input | 8 | Right write data |
| rp_rdata | output | 8 | Right registered read data |
| rp_standby | output | 1 | Right standby indication |
| rp_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The assertions check on every cycle the properties that hold locally:
- read latency and read-data hold;
- the left write landing in the array;
- set priority, clear and hold of each flag;
- a deselected port leaving its own flag alone.

Only the bench scenarios can show the behaviours that are end to end:
- the message byte passed through a mailbox word;
- read-before-write when the two ports meet on one address;
- a write by a deselected port leaving memory untouched;
- a port writing its own mailbox word leaving its own flag alone.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  localparam int unsigned DPMB_AW = 11;
  localparam int unsigned DPMB_DW = 8;
  localparam int unsigned DPMB_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec #(
  parameter int unsigned AW = 11,
  parameter logic [AW-1:0] OWN_MB = '0,
  parameter logic [AW-1:0] PEER_MB = '1
) (
  input  logic          cs,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  output logic          wr_en,
  output logic          rd_en,
  output logic          notify_peer,
  output logic          clr_own,
  output logic          standby
);
  logic hit_own;
  logic hit_peer;

  always_comb begin
    hit_own     = (addr == OWN_MB);
    hit_peer    = (addr == PEER_MB);
    standby     = ~cs;
    wr_en       = cs & we;
    rd_en       = cs & ~we & oe;
    notify_peer = cs & we & hit_peer;
    clr_own     = cs & oe & hit_own;
  end
endmodule

// File: rtl/dpmb_mbox_flag.sv
module dpmb_mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic irq_n
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_req | clr_req;
    flag_d  = flag_q;
    if (set_req) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign irq_n = ~flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> !irq_n); // R9
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_req) |=> irq_n); // R7
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_req && !clr_req) |=> $stable(irq_n)); // R13
endmodule

// File: rtl/dpmb_array.sv
module dpmb_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_peek;
  logic [DW-1:0] b_peek;

  always_comb begin
    a_peek = mem[a_addr];
    b_peek = mem[b_addr];
  end

  // Port b is written first so that port a (left) wins a same-address clash.
  always_ff @(posedge clk) begin
    if (b_wr) begin
      mem[b_addr] <= b_wdata;
    end
    if (a_wr) begin
      mem[a_addr] <= a_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (a_rd) begin
      a_rdata <= a_peek;
    end
  end

  always_ff @(posedge clk) begin
    if (b_rd) begin
      b_rdata <= b_peek;
    end
  end

  AST_RD_LAT_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd |=> (a_rdata === $past(a_peek))); // R1
  AST_RD_LAT_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_rd |=> (b_rdata === $past(b_peek))); // R1
  AST_RD_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rd |=> $stable(a_rdata)); // R2
  AST_RD_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    !b_rd |=> $stable(b_rdata)); // R2
  AST_LEFT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> (mem[$past(a_addr)] == $past(a_wdata))); // R3
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
  import dpmb_pkg::*;
#(
  parameter int unsigned AW = DPMB_AW,
  parameter int unsigned DW = DPMB_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lp_cs,
  input  logic          lp_we,
  input  logic          lp_oe,
  input  logic [AW-1:0] lp_addr,
  input  logic [DW-1:0] lp_wdata,
  output logic [DW-1:0] lp_rdata,
  output logic          lp_standby,
  output logic          lp_irq_n,
  input  logic          rp_cs,
  input  logic          rp_we,
  input  logic          rp_oe,
  input  logic [AW-1:0] rp_addr,
  input  logic [DW-1:0] rp_wdata,
  output logic [DW-1:0] rp_rdata,
  output logic          rp_standby,
  output logic          rp_irq_n
);
  localparam logic [AW-1:0] MB_HI = {AW{1'b1}};
  localparam logic [AW-1:0] MB_LO = MB_HI - 1'b1;
  localparam int unsigned NP = DPMB_PORTS;

  // reset: asserted asynchronously, released after two clocks
  logic rst_s1_q;
  logic rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic          p_cs     [NP];
  logic          p_we     [NP];
  logic          p_oe     [NP];
  logic [AW-1:0] p_addr   [NP];
  logic          p_wr     [NP];
  logic          p_rd     [NP];
  logic          p_notify [NP];
  logic          p_clr    [NP];
  logic          p_stby   [NP];
  logic          p_irq_n  [NP];

  always_comb begin
    p_cs[PORT_L]   = lp_cs;
    p_we[PORT_L]   = lp_we;
    p_oe[PORT_L]   = lp_oe;
    p_addr[PORT_L] = lp_addr;
    p_cs[PORT_R]   = rp_cs;
    p_we[PORT_R]   = rp_we;
    p_oe[PORT_R]   = rp_oe;
    p_addr[PORT_R] = rp_addr;
  end

  genvar gp;
  generate
    for (gp = 0; gp < NP; gp++) begin : g_port
      // left clears at MB_LO and notifies at MB_HI; right is the mirror
      localparam logic [AW-1:0] OWN  = (gp == PORT_L) ? MB_LO : MB_HI;
      localparam logic [AW-1:0] PEER = (gp == PORT_L) ? MB_HI : MB_LO;

      dpmb_port_dec #(.AW(AW), .OWN_MB(OWN), .PEER_MB(PEER)) u_dec (
        .cs          (p_cs[gp]),
        .we          (p_we[gp]),
        .oe          (p_oe[gp]),
        .addr        (p_addr[gp]),
        .wr_en       (p_wr[gp]),
        .rd_en       (p_rd[gp]),
        .notify_peer (p_notify[gp]),
        .clr_own     (p_clr[gp]),
        .standby     (p_stby[gp])
      );

      dpmb_mbox_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_s2_q),
        .set_req (p_notify[NP-1-gp]),
        .clr_req (p_clr[gp]),
        .irq_n   (p_irq_n[gp])
      );
    end
  endgenerate

  dpmb_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_s2_q),
    .a_wr    (p_wr[PORT_L]),
    .a_rd    (p_rd[PORT_L]),
    .a_addr  (lp_addr),
    .a_wdata (lp_wdata),
    .a_rdata (lp_rdata),
    .b_wr    (p_wr[PORT_R]),
    .b_rd    (p_rd[PORT_R]),
    .b_addr  (rp_addr),
    .b_wdata (rp_wdata),
    .b_rdata (rp_rdata)
  );

  always_comb begin
    lp_standby = p_stby[PORT_L];
    rp_standby = p_stby[PORT_R];
    lp_irq_n   = p_irq_n[PORT_L];
    rp_irq_n   = p_irq_n[PORT_R];
  end

  AST_STBY_KEEPS_L: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (!lp_cs && !(rp_cs && rp_we && rp_addr == MB_LO)) |=> $stable(lp_irq_n)); // R11
  AST_STBY_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (!rp_cs && !(lp_cs && lp_we && lp_addr == MB_HI)) |=> $stable(rp_irq_n)); // R11
  AST_RESET_IRQ: assert property (@(posedge clk)
    !rst_s2_q |-> (lp_irq_n && rp_irq_n)); // R12
endmodule

// File: tb/dpmb_top_test.sv
module dpmb_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          lp_cs, lp_we, lp_oe;
  logic [AW-1:0] lp_addr;
  logic [DW-1:0] lp_wdata;
  logic [DW-1:0] lp_rdata;
  logic          lp_standby, lp_irq_n;
  logic          rp_cs, rp_we, rp_oe;
  logic [AW-1:0] rp_addr;
  logic [DW-1:0] rp_wdata;
  logic [DW-1:0] rp_rdata;
  logic          rp_standby, rp_irq_n;

  int n_checks;
  int n_bad;
  bit finished;

  dpmb_top uut (
    .clk(clk), .rst_n(rst_n),
    .lp_cs(lp_cs), .lp_we(lp_we), .lp_oe(lp_oe), .lp_addr(lp_addr),
    .lp_wdata(lp_wdata), .lp_rdata(lp_rdata), .lp_standby(lp_standby),
    .lp_irq_n(lp_irq_n),
    .rp_cs(rp_cs), .rp_we(rp_we), .rp_oe(rp_oe), .rp_addr(rp_addr),
    .rp_wdata(rp_wdata), .rp_rdata(rp_rdata), .rp_standby(rp_standby),
    .rp_irq_n(rp_irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // move one clock edge forward, then settle away from the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drv_l(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    lp_cs = cs; lp_we = we; lp_oe = oe; lp_addr = a; lp_wdata = d;
  endtask

  task automatic drv_r(input logic cs, input logic we, input logic oe,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    rp_cs = cs; rp_we = we; rp_oe = oe; rp_addr = a; rp_wdata = d;
  endtask

  task automatic idle();
    drv_l(0, 0, 0, '0, '0);
    drv_r(0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
    check("R12 left irq after reset", lp_irq_n, 1);
    check("R12 right irq after reset", rp_irq_n, 1);
    check("R11 left standby idle", lp_standby, 1);
    check("R11 right standby idle", rp_standby, 1);
  endtask

  task automatic t_basic_rw();
    drv_l(1, 1, 0, 11'h005, 8'hA5);
    drv_r(1, 1, 0, 11'h123, 8'h3C);
    step();
    drv_l(1, 0, 1, 11'h123, 8'h00);
    drv_r(1, 0, 1, 11'h005, 8'h00);
    step();
    check("R1 left reads right's word", lp_rdata, 8'h3C);
    check("R1 right reads left's word", rp_rdata, 8'hA5);
    idle();
    drv_l(1, 1, 0, 11'h000, 8'hEE);
    step();
    check("R2 left rdata held", lp_rdata, 8'h3C);
    check("R2 right rdata held", rp_rdata, 8'hA5);
    idle();
    drv_r(1, 0, 1, 11'h000, 8'h00);
    step();
    check("R1 right reads address 0", rp_rdata, 8'hEE);
    idle();
  endtask

  task automatic t_collide();
    drv_l(1, 1, 0, 11'h040, 8'h11);
    drv_r(1, 1, 0, 11'h040, 8'h22);
    step();
    idle();
    drv_r(1, 0, 1, 11'h040, 8'h00);
    step();
    check("R3 left wins same-address write", rp_rdata, 8'h11);
    idle();
  endtask

  task automatic t_read_old();
    drv_l(1, 1, 0, 11'h050, 8'h77);
    step();
    drv_l(1, 0, 1, 11'h050, 8'h00);
    drv_r(1, 1, 0, 11'h050, 8'h88);
    step();
    check("R4 read sees pre-write data", lp_rdata, 8'h77);
    drv_r(0, 0, 0, '0, '0);
    step();
    check("R4 next read sees new data", lp_rdata, 8'h88);
    idle();
  endtask

  task automatic t_left_mailbox();
    drv_r(1, 1, 0, 11'h7FE, 8'h5A);
    step();
    idle();
    check("R5 left irq raised by right write", lp_irq_n, 0);
    check("R13 right irq untouched", rp_irq_n, 1);
    drv_l(1, 1, 0, 11'h7FE, 8'h5B);
    step();
    check("R13 own mailbox write w/o oe keeps flag", lp_irq_n, 0);
    check("R13 left own-mailbox write no right irq", rp_irq_n, 1);
    drv_l(1, 0, 1, 11'h7FE, 8'h00);
    step();
    check("R10 left reads mailbox word", lp_rdata, 8'h5B);
    check("R7 left irq cleared by read", lp_irq_n, 1);
    idle();
    drv_r(1, 1, 0, 11'h7FE, 8'h01);
    step();
    check("R5 left irq raised again", lp_irq_n, 0);
    drv_r(0, 0, 0, '0, '0);
    drv_l(1, 1, 1, 11'h7FE, 8'hC3);
    step();
    check("R7 clear with we=1 and oe=1", lp_irq_n, 1);
    idle();
    drv_r(1, 0, 1, 11'h7FE, 8'h00);
    step();
    check("R10 mailbox write stored", rp_rdata, 8'hC3);
    idle();
  endtask

  task automatic t_right_mailbox();
    drv_l(1, 1, 0, 11'h7FF, 8'hA1);
    step();
    idle();
    check("R6 right irq raised by left write", rp_irq_n, 0);
    check("R13 left irq untouched", lp_irq_n, 1);
    drv_r(1, 0, 1, 11'h7FF, 8'h00);
    step();
    check("R10 right reads mailbox word", rp_rdata, 8'hA1);
    check("R8 right irq cleared by read", rp_irq_n, 1);
    idle();
    drv_l(1, 1, 0, 11'h7FF, 8'hA2);
    step();
    drv_l(0, 0, 0, '0, '0);
    drv_r(1, 1, 1, 11'h7FF, 8'hA3);
    step();
    check("R8 right clear with we=1", rp_irq_n, 1);
    idle();
  endtask

  task automatic t_set_wins();
    drv_r(1, 1, 0, 11'h7FE, 8'h66);
    drv_l(1, 0, 1, 11'h7FE, 8'h00);
    step();
    check("R9 set beats clear", lp_irq_n, 0);
    idle();
    drv_l(1, 1, 0, 11'h7FF, 8'h67);
    drv_r(1, 0, 1, 11'h7FF, 8'h00);
    step();
    check("R9 set beats clear on right", rp_irq_n, 0);
    idle();
  endtask

  task automatic t_standby();
    // both flags are set from the previous scenario
    drv_l(1, 1, 0, 11'h060, 8'h44);
    #1;
    check("R11 left standby low when selected", lp_standby, 0);
    step();
    idle();
    drv_l(1, 0, 1, 11'h060, 8'h00);
    step();
    check("R1 left reads 0x060", lp_rdata, 8'h44);
    drv_l(0, 1, 1, 11'h060, 8'h99);
    drv_r(0, 0, 1, 11'h7FF, 8'h00);
    #1;
    check("R11 left standby follows cs", lp_standby, 1);
    check("R11 right standby follows cs", rp_standby, 1);
    step();
    check("R11 deselected right keeps its flag", rp_irq_n, 0);
    drv_l(0, 0, 1, 11'h7FE, 8'h00);
    drv_r(0, 1, 0, 11'h123, 8'h99);
    step();
    check("R11 deselected left keeps its flag", lp_irq_n, 0);
    check("R11 deselected read leaves rdata", lp_rdata, 8'h44);
    idle();
    drv_r(0, 1, 0, 11'h7FF, 8'h00);
    drv_l(1, 0, 1, 11'h7FE, 8'h00);
    step();
    check("R7 clear from standby state", lp_irq_n, 1);
    drv_r(0, 1, 0, 11'h7FE, 8'h00);
    drv_l(1, 0, 1, 11'h060, 8'h00);
    step();
    check("R11 deselected write did not set left flag", lp_irq_n, 1);
    check("R11 deselected write not stored", lp_rdata, 8'h44);
    idle();
    drv_l(1, 0, 1, 11'h123, 8'h00);
    step();
    check("R11 deselected right write not stored", lp_rdata, 8'h3C);
    idle();
  endtask

  initial begin
    n_checks = 0;
    n_bad = 0;
    finished = 0;
    rst_n = 1'b0;
    idle();
    t_reset();
    t_basic_rw();
    t_collide();
    t_read_old();
    t_left_mailbox();
    t_right_mailbox();
    t_set_wins();
    t_standby();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule